// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of a free-running event timer. It watches a 64-bit main counter shared by all channels and raises a one-cycle interrupt pulse when the counter reaches the channel's comparator. The counter may step past the comparator between two samples, and that still counts as reaching it. The channel can fire once (one-shot) or reload itself (periodic). It can also narrow its comparison to the low 32 bits of the counter. A small register window holds the channel's configuration, its comparator and a route register that does nothing. Software reaches the window through a 32-bit word-indexed write port and a combinational read port.

Channel 0 is the full-featured channel: it can run periodic and can compare all 64 bits. Every other channel is limited to 32-bit one-shot operation. A legacy routing input overrides the interrupt line number chosen by channels 0 and 1. Only edge-style delivery is built, so the status output never asserts.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the configuration word (word 0) reads 0x0000_0030 on channel 0 and 0x0000_0000 on other channels. The comparator reads all ones, with its upper half (word 3) reading zero on 32-bit-only channels. Word 1 reads the ROUTE_CAP parameter, and irq_o is low.
- R2: Words 4 and 5 (route register) read as zero. Writes to them change no register the channel holds.
- R3: Configuration bits in mask 0xFFFF_80B1 keep their value on a write. The other bits (1, 2, 3, 6, 8..14) take the written value, subject to R4.
- R4: On a channel other than 0, configuration bit 3 (periodic) and bit 8 (force 32-bit) always read zero, and the channel always runs in 32-bit mode.
- R5: An interrupt is produced only while glb_en_i and configuration bit 2 (interrupt enable) are both set.
- R6: irq_o pulses for one cycle, one clock after the sampled counter first equals or steps past the comparator. The test is an equality on the first armed cycle and a crossing since the previous sample after that.
- R7: With bit 3 set, a comparator write also stores the written half as the period. Each match then advances the comparator by the period.
- R8: With bit 8 set (or per R4), word 3 reads zero, writes to word 3 are ignored, and only the low 32 counter bits are compared.
- R9: In 32-bit one-shot mode, an extra pulse is raised when the low 32 counter bits wrap past zero.
- R10: A periodic channel whose period is zero raises at most one interrupt until its comparator or configuration is written again.
- R11: With legacy_i set, route_o is 0 on channel 0 and 8 on channel 1. Otherwise route_o is configuration bits [13:9].
- R12: sts_o stays low, including in the cycles where irq_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global enable for interrupt generation |
| legacy_i | input | 1 | Legacy routing override |
| reg_wr_i | input | 1 | Register write strobe |
| reg_word_i | input | 3 | Word index within the channel window (byte offset / 4) |
| reg_wdata_i | input | CNT_W/2 | Write data |
| reg_rdata_o | output | CNT_W/2 | Read data for reg_word_i |
| irq_o | output | 1 | One-cycle interrupt pulse |
| route_o | output | ROUTE_W | Selected interrupt line number |
| sts_o | output | 1 | Level-mode status, held low |

## Verification
Every cycle, the assertions check four things: read-only configuration bits, the capability limits of the narrow channels, the legacy route values, and that route-register writes leave the comparator alone. They also check that no pulse appears without the global enable. The bench's scenarios are needed for the timing-dependent behaviour: the equality and crossing match, the periodic advance and its zero-period limit, the extra pulse on a 32-bit wrap, and the 64-bit versus 32-bit compare. Each of these needs a chosen sequence of counter values and a known comparator.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [31:0] CFG_RO_MASK = 32'hFFFF_80B1;
  localparam int IEN_B      = 2;
  localparam int PERIODIC_B = 3;
  localparam int PER_CAP_B  = 4;
  localparam int WIDE_CAP_B = 5;
  localparam int FORCE32_B  = 8;
  localparam int ROUTE_LSB  = 9;

  typedef enum logic [2:0] {
    W_CFG_LO = 3'd0,
    W_CFG_HI = 3'd1,
    W_CMP_LO = 3'd2,
    W_CMP_HI = 3'd3,
    W_RTE_LO = 3'd4,
    W_RTE_HI = 3'd5
  } word_e;
endpackage

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int CHAN_IDX = 0,
  parameter int ROUTE_W  = 5
) (
  input  logic               legacy_i,
  input  logic [ROUTE_W-1:0] fld_i,
  output logic [ROUTE_W-1:0] route_o
);
  generate
    if (CHAN_IDX == 0) begin : g_leg0
      assign route_o = legacy_i ? ROUTE_W'(0) : fld_i;
    end else if (CHAN_IDX == 1) begin : g_leg1
      assign route_o = legacy_i ? ROUTE_W'(8) : fld_i;
    end else begin : g_plain
      logic unused_leg;
      assign unused_leg = legacy_i;
      assign route_o    = fld_i;
    end
  endgenerate
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int CNT_W    = 64,
  parameter int ROUTE_W  = 5,
  parameter logic [CNT_W/2-1:0] ROUTE_CAP = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [2:0]         word_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               adv_i,
  output logic [CNT_W/2-1:0] rdata_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [CNT_W-1:0]   per_o,
  output logic               int_en_o,
  output logic               periodic_o,
  output logic               mode32_o,
  output logic [ROUTE_W-1:0] route_fld_o,
  output logic               rearm_o
);
  localparam int HALF = CNT_W / 2;
  localparam bit FULL_CAP = (CHAN_IDX == 0);
  localparam logic [HALF-1:0] CAP_BITS =
    FULL_CAP ? HALF'((1 << PER_CAP_B) | (1 << WIDE_CAP_B)) : '0;
  localparam logic [HALF-1:0] NO_CAP_CLR =
    FULL_CAP ? '0 : HALF'((1 << PERIODIC_B) | (1 << FORCE32_B));
  localparam logic [HALF-1:0] WMASK = ~HALF'(CFG_RO_MASK) & ~NO_CAP_CLR;

  logic [HALF-1:0]  cfg_q, cfg_n;
  logic [CNT_W-1:0] cmp_q, cmp_n, per_q, per_n, cmp_eff, sum;
  logic             mode32, periodic, upd_en;

  assign mode32   = !FULL_CAP || cfg_q[FORCE32_B];
  assign periodic = cfg_q[PERIODIC_B];
  assign cmp_eff  = mode32 ? {{HALF{1'b0}}, cmp_q[HALF-1:0]} : cmp_q;
  assign sum      = cmp_eff + per_q;
  assign upd_en   = wr_i || adv_i;

  always_comb begin
    cfg_n = cfg_q;
    cmp_n = cmp_q;
    per_n = per_q;
    if (adv_i)
      cmp_n = mode32 ? {{HALF{1'b0}}, sum[HALF-1:0]} : sum;
    if (wr_i) begin
      case (word_i)
        W_CFG_LO: cfg_n = (cfg_q & ~WMASK) | (wdata_i & WMASK);
        W_CMP_LO: begin
          cmp_n[HALF-1:0] = wdata_i;
          if (mode32) cmp_n[CNT_W-1:HALF] = '0;
          if (periodic) per_n[HALF-1:0] = wdata_i;
        end
        W_CMP_HI: begin
          if (!mode32) begin
            cmp_n[CNT_W-1:HALF] = wdata_i;
            if (periodic) per_n[CNT_W-1:HALF] = wdata_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CAP_BITS;
      cmp_q <= '1;
      per_q <= '0;
    end else if (upd_en) begin
      cfg_q <= cfg_n;
      cmp_q <= cmp_n;
      per_q <= per_n;
    end
  end

  always_comb begin
    case (word_i)
      W_CFG_LO: rdata_o = cfg_q;
      W_CFG_HI: rdata_o = ROUTE_CAP;
      W_CMP_LO: rdata_o = cmp_eff[HALF-1:0];
      W_CMP_HI: rdata_o = cmp_eff[CNT_W-1:HALF];
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o       = cmp_eff;
  assign per_o       = per_q;
  assign int_en_o    = cfg_q[IEN_B];
  assign periodic_o  = periodic;
  assign mode32_o    = mode32;
  assign route_fld_o = cfg_q[ROUTE_LSB +: ROUTE_W];
  assign rearm_o     = wr_i && (word_i == W_CFG_LO || word_i == W_CMP_LO ||
                                word_i == W_CMP_HI);
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             armed_i,
  input  logic             mode32_i,
  input  logic             periodic_i,
  input  logic             rearm_i,
  output logic             adv_o,
  output logic             irq_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cur, prv;
  logic             en_q, spent_q, spent_n, irq_q;
  logic             crossed, match, wrap, hit;

  assign cur = mode32_i ? {{HALF{1'b0}}, cnt_i[HALF-1:0]} : cnt_i;
  assign prv = mode32_i ? {{HALF{1'b0}}, cnt_q[HALF-1:0]} : cnt_q;

  always_comb begin
    if (cur >= prv) crossed = (prv < cmp_i) && (cmp_i <= cur);
    else            crossed = (cmp_i > prv) || (cmp_i <= cur);
  end

  assign match = en_q ? crossed : (cur == cmp_i);
  assign wrap  = en_q && mode32_i && !periodic_i && (cur < prv);
  assign hit   = armed_i && !spent_q && match;
  assign adv_o = hit && periodic_i;

  always_comb begin
    spent_n = spent_q;
    if (rearm_i)                            spent_n = 1'b0;
    else if (adv_o && (per_i == '0))        spent_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      en_q    <= 1'b0;
      spent_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_i;
      en_q    <= armed_i;
      spent_q <= spent_n;
      irq_q   <= hit || (armed_i && wrap);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CHAN_IDX = 0,
  parameter int CNT_W    = 64,
  parameter int ROUTE_W  = 5,
  parameter logic [CNT_W/2-1:0] ROUTE_CAP = 32'h00FF_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   main_cnt_i,
  input  logic               glb_en_i,
  input  logic               legacy_i,
  input  logic               reg_wr_i,
  input  logic [2:0]         reg_word_i,
  input  logic [CNT_W/2-1:0] reg_wdata_i,
  output logic [CNT_W/2-1:0] reg_rdata_o,
  output logic               irq_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic               sts_o
);
  logic [CNT_W-1:0]   cmp, per;
  logic               int_en, periodic, mode32, rearm, adv;
  logic [ROUTE_W-1:0] route_fld;

  tmr_regs #(
    .CHAN_IDX(CHAN_IDX), .CNT_W(CNT_W), .ROUTE_W(ROUTE_W), .ROUTE_CAP(ROUTE_CAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .word_i(reg_word_i),
    .wdata_i(reg_wdata_i), .adv_i(adv), .rdata_o(reg_rdata_o),
    .cmp_o(cmp), .per_o(per), .int_en_o(int_en), .periodic_o(periodic),
    .mode32_o(mode32), .route_fld_o(route_fld), .rearm_o(rearm)
  );

  tmr_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt_i(main_cnt_i), .cmp_i(cmp), .per_i(per),
    .armed_i(glb_en_i && int_en), .mode32_i(mode32), .periodic_i(periodic),
    .rearm_i(rearm), .adv_o(adv), .irq_o(irq_o)
  );

  tmr_route #(.CHAN_IDX(CHAN_IDX), .ROUTE_W(ROUTE_W)) u_route (
    .legacy_i(legacy_i), .fld_i(route_fld), .route_o(route_o)
  );

  // Edge delivery only: level-mode status is never raised.
  assign sts_o = 1'b0;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CHAN_IDX = 0,
  parameter int CNT_W    = 64,
  parameter int ROUTE_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en_i,
  input logic               legacy_i,
  input logic               reg_wr_i,
  input logic [2:0]         reg_word_i,
  input logic [CNT_W/2-1:0] reg_rdata_o,
  input logic               irq_o,
  input logic [ROUTE_W-1:0] route_o,
  input logic [CNT_W-1:0]   cmp
);
  localparam logic [31:0] RO_MASK  = 32'hFFFF_80B1;
  localparam logic [31:0] CAP_SEEN = (CHAN_IDX == 0) ? 32'h30 : 32'h0;

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(glb_en_i));

  p_ro_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word_i == 3'd0) |-> ((32'(reg_rdata_o) & RO_MASK) == CAP_SEEN));

  p_narrow_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN_IDX != 0 && reg_word_i == 3'd0) |-> (reg_rdata_o[3] == 1'b0 && reg_rdata_o[8] == 1'b0));

  p_route_wr_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_word_i == 3'd4 || reg_word_i == 3'd5)) |=> (cmp == $past(cmp) || irq_o));

  p_legacy_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_i && CHAN_IDX < 2) |-> (route_o == ((CHAN_IDX == 0) ? ROUTE_W'(0) : ROUTE_W'(8))));
endmodule

bind tmr_chan tmr_chan_chk #(.CHAN_IDX(CHAN_IDX), .CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .legacy_i(legacy_i),
  .reg_wr_i(reg_wr_i), .reg_word_i(reg_word_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .route_o(route_o), .cmp(cmp)
);

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;
  localparam logic [31:0] CAP = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        glb, leg, wr0, wr1;
  logic [2:0]  word;
  logic [31:0] wdata, rd0, rd1;
  logic        irq0, irq1, sts0, sts1;
  logic [4:0]  rte0, rte1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_chan #(.CHAN_IDX(0), .ROUTE_CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_cnt_i(cnt), .glb_en_i(glb), .legacy_i(leg),
    .reg_wr_i(wr0), .reg_word_i(word), .reg_wdata_i(wdata), .reg_rdata_o(rd0),
    .irq_o(irq0), .route_o(rte0), .sts_o(sts0));

  tmr_chan #(.CHAN_IDX(1), .ROUTE_CAP(CAP)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .main_cnt_i(cnt), .glb_en_i(glb), .legacy_i(leg),
    .reg_wr_i(wr1), .reg_word_i(word), .reg_wdata_i(wdata), .reg_rdata_o(rd1),
    .irq_o(irq1), .route_o(rte1), .sts_o(sts1));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input bit ch1, input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    word = w; wdata = d; wr0 = !ch1; wr1 = ch1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit ch1, input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    word = w;
    #1 d = ch1 ? rd1 : rd0;
  endtask

  // drive a counter value, return the pulse seen one clock later
  task automatic step(input logic [63:0] v, output logic p);
    @(negedge clk);
    cnt = v;
    @(posedge clk);
    #2 p = irq0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, 3'd0, d); chk("R1 cfg ch0", d, 32'h30);
    rd(1, 3'd0, d); chk("R1 cfg ch1", d, 32'h0);
    rd(0, 3'd1, d); chk("R1 cap", d, CAP);
    rd(0, 3'd2, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(0, 3'd3, d); chk("R1 cmp hi ch0", d, 32'hFFFF_FFFF);
    rd(1, 3'd3, d); chk("R1 cmp hi ch1", d, 32'h0);
    chk("R1 irq", {irq1, irq0}, 0);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wr(0, 3'd0, 32'hFFFF_FFFF); rd(0, 3'd0, d); chk("R3 mask ch0", d, 32'h7F7E);
    wr(1, 3'd0, 32'hFFFF_FFFF); rd(1, 3'd0, d); chk("R4 mask ch1", d, 32'h7E46);
    wr(1, 3'd0, 32'h10C);       rd(1, 3'd0, d); chk("R4 no periodic ch1", d, 32'h4);
    wr(1, 3'd3, 32'h77);        rd(1, 3'd3, d); chk("R4 ch1 hi zero", d, 32'h0);
    wr(0, 3'd0, 32'h0);         rd(0, 3'd0, d); chk("R3 restore", d, 32'h30);
    wr(1, 3'd0, 32'h0);
    wr(0, 3'd4, 32'hFFFF_FFFF); wr(0, 3'd5, 32'hFFFF_FFFF);
    rd(0, 3'd4, d); chk("R2 route lo", d, 32'h0);
    rd(0, 3'd5, d); chk("R2 route hi", d, 32'h0);
    rd(0, 3'd0, d); chk("R2 cfg kept", d, 32'h30);
    rd(0, 3'd2, d); chk("R2 cmp kept", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_oneshot64;
    logic p;
    glb = 1'b1;
    wr(0, 3'd0, 32'h4);
    wr(0, 3'd3, 32'h1); wr(0, 3'd2, 32'h10);
    step(64'h0_0000_0010, p); chk("R6 low32 eq not 64 match", p, 0);
    step(64'h1_0000_0008, p); chk("R6 below", p, 0);
    step(64'h1_0000_0020, p); chk("R6 step past", p, 1);
    chk("R12 sts", sts0, 0);
    step(64'h1_0000_0030, p); chk("R6 single pulse", p, 0);
  endtask

  task automatic t_gating;
    logic p;
    wr(0, 3'd3, 32'h0); wr(0, 3'd2, 32'h100);
    glb = 1'b0;
    step(64'h50, p);  step(64'h150, p); chk("R5 glb off", p, 0);
    glb = 1'b1; wr(0, 3'd0, 32'h0);
    step(64'h50, p);  step(64'h150, p); chk("R5 ien off", p, 0);
    wr(0, 3'd0, 32'h4);
    step(64'h50, p);  step(64'h150, p); chk("R5 both on", p, 1);
  endtask

  task automatic t_periodic;
    logic p;
    logic [31:0] d;
    wr(0, 3'd0, 32'hC);
    wr(0, 3'd3, 32'h0); wr(0, 3'd2, 32'h100);
    step(64'h80, p);  chk("R7 before", p, 0);
    step(64'h100, p); chk("R7 first", p, 1);
    step(64'h180, p); chk("R7 gap", p, 0);
    step(64'h200, p); chk("R7 second", p, 1);
    step(64'h2FF, p); chk("R7 gap2", p, 0);
    step(64'h300, p); chk("R7 third", p, 1);
    rd(0, 3'd2, d);   chk("R7 cmp advanced", d, 32'h400);
  endtask

  task automatic t_zero_period;
    logic p;
    wr(0, 3'd2, 32'h0);
    wr(0, 3'd0, 32'h4); wr(0, 3'd2, 32'h500);
    wr(0, 3'd0, 32'hC);
    step(64'h400, p); chk("R10 before", p, 0);
    step(64'h500, p); chk("R10 one hit", p, 1);
    step(64'h600, p); chk("R10 after", p, 0);
    step(64'h10, p);
    step(64'h550, p); chk("R10 no second", p, 0);
  endtask

  task automatic t_mode32;
    logic p;
    logic [31:0] d;
    glb = 1'b0;
    wr(0, 3'd0, 32'h104);
    wr(0, 3'd2, 32'h20); wr(0, 3'd3, 32'hABCD);
    rd(0, 3'd3, d); chk("R8 hi reads zero", d, 32'h0);
    rd(0, 3'd2, d); chk("R8 lo kept", d, 32'h20);
    step(64'h5_0000_0010, p);
    glb = 1'b1;
    step(64'h5_0000_0018, p); chk("R8 below", p, 0);
    step(64'h5_0000_0020, p); chk("R8 low32 match", p, 1);
    step(64'h5_0000_0030, p); chk("R8 after", p, 0);
    step(64'h5_FFFF_FFF0, p); chk("R9 pre wrap", p, 0);
    step(64'h6_0000_0005, p); chk("R9 wrap pulse", p, 1);
    chk("R12 sts wrap", sts0, 0);
    step(64'h6_0000_0010, p); chk("R9 after wrap", p, 0);
  endtask

  task automatic t_route;
    wr(1, 3'd0, 32'hA00); wr(0, 3'd0, 32'h600);
    #1 chk("R11 ch1 field", rte1, 5);
    chk("R11 ch0 field", rte0, 3);
    leg = 1'b1;
    #1 chk("R11 ch0 legacy", rte0, 0);
    chk("R11 ch1 legacy", rte1, 8);
    leg = 1'b0;
    #1 chk("R11 ch0 back", rte0, 3);
  endtask

  initial begin
    rst_n = 1'b0; cnt = '0; glb = 1'b0; leg = 1'b0;
    wr0 = 1'b0; wr1 = 1'b0; word = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_oneshot64();
    t_gating();
    t_periodic();
    t_zero_period();
    t_mode32();
    t_route();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule